// File: doc/BRIEF.md
# Reversible-Cell Carry-Bypass Adder

A combinational N-bit binary adder built only from instances of one three-input, three-output reversible cell. The cell passes its first input through, gives the exclusive-or of its first two inputs, and gives the AND of the first two inputs folded by exclusive-or into the third. Each bit of the adder is a full adder made of two such cells. One of these cells has its third input tied to zero. The two outputs that carry no result are kept as garbage.

Bits are grouped into consecutive segments whose widths come from a parameter list. Each segment ripples its carry through its own full adders. The same segment also builds a group propagate, which is the AND of its per-bit exclusive-ors, using a chain of cells. One more cell gates the segment carry-in with that group propagate, so that a carry can pass around the segment whenever every bit would propagate it. The widths may be uniform. They may also follow a symmetric schedule that starts narrow at both ends and grows toward the middle, with an even number of segments. Checks made at elaboration reject a list whose widths do not add up to N, and in the variable mode they also reject a list that breaks the schedule.

Every unused cell output is gathered into one debug vector, so that no net is left dangling. Cell delay figures, cost accounting and physical reversibility are not modelled.

Top module: `rev_skip_adder`

## Requirements
- R1: `{cout_o, sum_o}` equals `a_i + b_i + cin_i` for every input combination.
- R2: For every bit i, `dbg_o[2*i]` equals `a_i[i]`. This is the pass-through output of the bit's first cell.
- R3: For every bit i, `dbg_o[2*i+1]` equals `a_i[i] ^ b_i[i]`. This is the bit propagate, taken from the bit's second cell.
- R4: For a segment that starts at bit s and is w bits wide, `dbg_o[2*N + 2*(s+w) - 2]` equals the AND of the propagates of bits s to s+w-1.
- R5: For the same segment, `dbg_o[2*N + 2*(s+w) - 1]` equals that group propagate XOR the carry entering bit s. The carry entering bit s is the carry of the low s bits of `a_i + b_i + cin_i`.
- R6: When every bit propagates (`b_i == ~a_i`), the carry-in is passed through every segment. `cin_i=1` gives sum 0 and `cout_o=1`. `cin_i=0` gives sum all ones and `cout_o=0`.
- R7: A carry generated in bit 0 ripples across all segment boundaries. With `a_i=1`, `b_i` all ones and `cin_i=0`, the result is sum 0 and `cout_o=1`.
- R8: Inside a segment at s, link k (0 ≤ k ≤ w-2) of the AND chain has x equal to the AND of the propagates of bits s to s+k. `dbg_o[2*N+2*s+2*k]` equals x, and `dbg_o[2*N+2*s+2*k+1]` equals x XOR the propagate of bit s+k+1.
- R9: A segment's carry-out equals the ripple carry-out OR (group propagate AND segment carry-in), and this value always equals the plain ripple result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First addend |
| b_i | input | N | Second addend |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | N | Sum bits |
| cout_o | output | 1 | Carry out of the top bit |
| dbg_o | output | 4*N | Garbage outputs of all cells. The low 2N bits hold the per-bit cells; the high 2N bits hold the segment AND-chain and bypass cells |

## Verification
The bypass path and the ripple path both decide the same segment carry when all of a segment's bits propagate and a carry enters it. The bench provokes this by filling one segment at a time with a propagating pattern (`a` set, `b` clear). At the same time it creates a carry just below that segment by setting the neighbouring bit in both addends. It judges the outcome through the total sum and carry, and through the bypass cell's debug outputs. Those outputs must show a group propagate of 1, and a value of group propagate XOR carry-in that matches the carry the bench computes itself.

// File: rtl/rev_skip_pkg.sv
// Package: shared types and schedule helpers for the reversible-cell adder.
// Assumes segment widths fit in eight bits.
package rev_skip_pkg;

    // Width of one entry in the segment width list.
    typedef logic [7:0] seg_w_t;

    // Garbage outputs produced per bit by the full adder (two cells).
    localparam int unsigned ADD_GARB_PER_BIT = 2;

    // Garbage outputs produced per bit by the segment control cells.
    localparam int unsigned CTL_GARB_PER_BIT = 2;

endpackage

// File: rtl/peres_cell.sv
// Module: three-in / three-out reversible cell.
// p = a, q = a ^ b, r = (a & b) ^ c. Purely combinational, no assumptions.
module peres_cell (
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic p_o,
    output logic q_o,
    output logic r_o
);

    // Compute the three reversible outputs.
    always_comb begin
        p_o = a_i;
        q_o = a_i ^ b_i;
        r_o = (a_i & b_i) ^ c_i;
    end

endmodule

// File: rtl/rev_full_adder.sv
// Module: one-bit full adder from two reversible cells.
// The first cell has its third input tied to zero. Its pass-through output
// and the second cell's pass-through output (the propagate) are the garbage.
module rev_full_adder (
    input  logic       a_i,
    input  logic       b_i,
    input  logic       cin_i,
    output logic       sum_o,
    output logic       cout_o,
    output logic       prop_o,
    output logic [1:0] garb_o
);

    logic x_pass, x_prop, x_gen, y_prop;

    // First cell: forms a^b and a&b from the addends, constant input zero.
    peres_cell u_c0 (
        .a_i (a_i),
        .b_i (b_i),
        .c_i (1'b0),
        .p_o (x_pass),
        .q_o (x_prop),
        .r_o (x_gen)
    );

    // Second cell: folds in the carry to give sum and carry-out.
    peres_cell u_c1 (
        .a_i (x_prop),
        .b_i (cin_i),
        .c_i (x_gen),
        .p_o (y_prop),
        .q_o (sum_o),
        .r_o (cout_o)
    );

    // Route propagate and garbage to the outputs.
    always_comb begin
        prop_o = y_prop;
        garb_o = {y_prop, x_pass};
    end

    // Check the bit arithmetic against a direct count of ones.
    always_comb begin
        AST_FA_ARITH: assert ({cout_o, sum_o} == (2'(a_i) + 2'(b_i) + 2'(cin_i)))
            else $error("full adder arithmetic mismatch"); // R1
    end

endmodule

// File: rtl/rev_skip_segment.sv
// Module: one bypass segment of W bits.
// It ripples the carry through W full adders, ANDs the W propagates with a
// chain of W-1 cells, and gates the segment carry-in with one more cell.
// Its carry-out is ripple | (group & cin). Assumes W >= 1.
module rev_skip_segment #(
    parameter int unsigned W = 4
) (
    input  logic           cin_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [W-1:0]   sum_o,
    output logic           cout_o,
    output logic [2*W-1:0] add_garb_o,
    output logic [2*W-1:0] ctl_garb_o
);

    localparam int unsigned LINKS = W - 1;

    logic [W:0]   rip_c;
    logic [W-1:0] prop;
    logic [W-1:0] run_and;
    logic         grp_p;
    logic         byp_and;
    logic         byp_p, byp_q;

    // Feed the segment carry into the ripple chain.
    always_comb rip_c[0] = cin_i;

    // Ripple chain of full adders.
    for (genvar i = 0; i < W; i++) begin : g_bit
        rev_full_adder u_fa (
            .a_i    (a_i[i]),
            .b_i    (b_i[i]),
            .cin_i  (rip_c[i]),
            .sum_o  (sum_o[i]),
            .cout_o (rip_c[i+1]),
            .prop_o (prop[i]),
            .garb_o (add_garb_o[2*i +: 2])
        );
    end

    // Start the AND chain with the lowest propagate.
    always_comb run_and[0] = prop[0];

    // AND chain: each link ANDs the running value with the next propagate.
    for (genvar k = 0; k < LINKS; k++) begin : g_link
        peres_cell u_and (
            .a_i (run_and[k]),
            .b_i (prop[k+1]),
            .c_i (1'b0),
            .p_o (ctl_garb_o[2*k]),
            .q_o (ctl_garb_o[2*k+1]),
            .r_o (run_and[k+1])
        );
    end

    // The group propagate is the last value of the chain.
    always_comb grp_p = run_and[W-1];

    // Bypass cell: gates the segment carry-in with the group propagate.
    peres_cell u_byp (
        .a_i (grp_p),
        .b_i (cin_i),
        .c_i (1'b0),
        .p_o (byp_p),
        .q_o (byp_q),
        .r_o (byp_and)
    );

    // Place bypass garbage and form the segment carry-out.
    always_comb begin
        ctl_garb_o[2*W-2] = byp_p;
        ctl_garb_o[2*W-1] = byp_q;
        cout_o            = rip_c[W] | byp_and;
    end

    // Guard the group propagate, the bypass path and the segment sum.
    always_comb begin
        AST_GROUP_AND: assert (grp_p == (&(a_i ^ b_i)))
            else $error("group propagate mismatch"); // R4
        AST_BYPASS_AGREES: assert (!(grp_p && (rip_c[W] != cin_i)))
            else $error("bypass disagrees with ripple"); // R9
        AST_SEG_SUM: assert ({cout_o, sum_o} == ((W+1)'(a_i) + (W+1)'(b_i) + (W+1)'(cin_i)))
            else $error("segment sum mismatch"); // R1
    end

endmodule

// File: rtl/rev_skip_adder.sv
// Module: N-bit carry-bypass adder from reversible cells (top).
// SEG_W[j] is the width of segment j, with segment 0 holding the low bits.
// With VAR_MODE set, the list must have an even count, be symmetric and
// not shrink toward the middle. dbg_o[2N-1:0] holds the per-bit garbage;
// dbg_o[4N-1:2N] holds the segment control garbage, two bits per bit
// position of the segment.
module rev_skip_adder
    import rev_skip_pkg::*;
#(
    parameter int unsigned N        = 16,
    parameter int unsigned NSEG     = 6,
    parameter seg_w_t [NSEG-1:0] SEG_W = {8'd2, 8'd3, 8'd3, 8'd3, 8'd3, 8'd2},
    parameter bit          VAR_MODE = 1'b1
) (
    input  logic [N-1:0]   a_i,
    input  logic [N-1:0]   b_i,
    input  logic           cin_i,
    output logic [N-1:0]   sum_o,
    output logic           cout_o,
    output logic [4*N-1:0] dbg_o
);

    localparam int unsigned ADD_W = ADD_GARB_PER_BIT * N;

    // First bit of segment j.
    function automatic int unsigned seg_start(input int unsigned j);
        int unsigned s = 0;
        for (int unsigned m = 0; m < j; m++) s += int'(SEG_W[m]);
        return s;
    endfunction

    // True when the schedule is symmetric, even and grows toward the middle.
    function automatic bit sched_ok();
        bit ok = (NSEG % 2 == 0);
        for (int unsigned m = 0; m < NSEG; m++) begin
            if (SEG_W[m] != SEG_W[NSEG-1-m]) ok = 1'b0;
            if (SEG_W[m] == 0) ok = 1'b0;
        end
        for (int unsigned m = 1; m < NSEG/2; m++)
            if (SEG_W[m] < SEG_W[m-1]) ok = 1'b0;
        return ok;
    endfunction

    localparam int unsigned TOTAL = seg_start(NSEG);

    // Elaboration checks on the width list.
    if (TOTAL != N) begin : g_bad_total
        $error("segment widths do not add up to N");
    end
    if (VAR_MODE && !sched_ok()) begin : g_bad_sched
        $error("variable schedule is not even, symmetric and centre-heavy");
    end

    logic [NSEG:0] seg_c;

    // Carry into the lowest segment.
    always_comb seg_c[0] = cin_i;

    // One bypass segment per width entry.
    for (genvar j = 0; j < NSEG; j++) begin : g_seg
        localparam int unsigned ST = seg_start(j);
        localparam int unsigned SW = int'(SEG_W[j]);
        rev_skip_segment #(
            .W (SW)
        ) u_seg (
            .cin_i      (seg_c[j]),
            .a_i        (a_i[ST +: SW]),
            .b_i        (b_i[ST +: SW]),
            .sum_o      (sum_o[ST +: SW]),
            .cout_o     (seg_c[j+1]),
            .add_garb_o (dbg_o[2*ST +: 2*SW]),
            .ctl_garb_o (dbg_o[ADD_W + 2*ST +: 2*SW])
        );
    end

    // Final carry is the top segment's carry-out.
    always_comb cout_o = seg_c[NSEG];

    // Whole-word arithmetic and per-bit pass-through garbage.
    always_comb begin
        AST_WORD_SUM: assert ({cout_o, sum_o} == ((N+1)'(a_i) + (N+1)'(b_i) + (N+1)'(cin_i)))
            else $error("adder total mismatch"); // R1
        for (int i = 0; i < int'(N); i++) begin
            AST_PASS_GARB: assert (dbg_o[2*i] == a_i[i])
                else $error("pass-through garbage mismatch"); // R2
            AST_PROP_GARB: assert (dbg_o[2*i+1] == (a_i[i] ^ b_i[i]))
                else $error("propagate garbage mismatch"); // R3
        end
    end

endmodule

// File: tb/rev_skip_adder_tb_top.sv
`timescale 1ns/1ps
module rev_skip_adder_tb_top;

    localparam int unsigned N    = 16;
    localparam int unsigned NSEG = 6;
    localparam logic [NSEG-1:0][7:0] SEG_W = {8'd2, 8'd3, 8'd3, 8'd3, 8'd3, 8'd2};
    localparam int unsigned DW   = 4*N;

    logic          clk = 1'b0;
    logic [N-1:0]  a, b, sum;
    logic          cin, cout;
    logic [DW-1:0] dbg;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    // 125 MHz clock.
    always #4 clk = ~clk;

    rev_skip_adder #(
        .N        (N),
        .NSEG     (NSEG),
        .SEG_W    (SEG_W),
        .VAR_MODE (1'b1)
    ) dut_i (
        .a_i    (a),
        .b_i    (b),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout),
        .dbg_o  (dbg)
    );

    // Expected garbage vector computed from the requirements.
    function automatic logic [DW-1:0] exp_dbg(input logic [N-1:0] x, input logic [N-1:0] y, input logic ci);
        logic [DW-1:0] d = '0;
        logic [N:0]    c;
        logic [N-1:0]  p;
        int            s = 0;
        c[0] = ci;
        for (int i = 0; i < int'(N); i++) begin
            p[i]    = x[i] ^ y[i];
            c[i+1]  = (x[i] & y[i]) | (p[i] & c[i]);
            d[2*i]  = x[i];
            d[2*i+1] = p[i];
        end
        for (int j = 0; j < int'(NSEG); j++) begin
            int  w = int'(SEG_W[j]);
            logic run = p[s];
            for (int k = 0; k < w-1; k++) begin
                d[2*N + 2*s + 2*k]     = run;
                d[2*N + 2*s + 2*k + 1] = run ^ p[s+k+1];
                run = run & p[s+k+1];
            end
            d[2*N + 2*(s+w) - 2] = run;
            d[2*N + 2*(s+w) - 1] = run ^ c[s];
            s += w;
        end
        return d;
    endfunction

    // Masks that select each requirement's fields in the garbage vector.
    function automatic logic [DW-1:0] mask_of(input int sel);
        logic [DW-1:0] m = '0;
        int s = 0;
        if (sel == 2) for (int i = 0; i < int'(N); i++) m[2*i] = 1'b1;
        if (sel == 3) for (int i = 0; i < int'(N); i++) m[2*i+1] = 1'b1;
        for (int j = 0; j < int'(NSEG); j++) begin
            int w = int'(SEG_W[j]);
            if (sel == 8) for (int k = 0; k < 2*(w-1); k++) m[2*N + 2*s + k] = 1'b1;
            if (sel == 4) m[2*N + 2*(s+w) - 2] = 1'b1;
            if (sel == 5) m[2*N + 2*(s+w) - 1] = 1'b1;
            s += w;
        end
        return m;
    endfunction

    // Record one comparison.
    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one vector and check all outputs after it settles.
    task automatic apply(input logic [N-1:0] x, input logic [N-1:0] y, input logic ci, input string tag);
        logic [DW-1:0] e;
        logic [N:0]    tot;
        @(posedge clk);
        #1;
        a = x; b = y; cin = ci;
        @(negedge clk);
        tot = (N+1)'(x) + (N+1)'(y) + (N+1)'(ci);
        e   = exp_dbg(x, y, ci);
        chk(tag, DW'({cout, sum}), DW'(tot));
        chk("R2", dbg & mask_of(2), e & mask_of(2));
        chk("R3", dbg & mask_of(3), e & mask_of(3));
        chk("R4", dbg & mask_of(4), e & mask_of(4));
        chk("R5", dbg & mask_of(5), e & mask_of(5));
        chk("R8", dbg & mask_of(8), e & mask_of(8));
    endtask

    // Random word of N bits.
    function automatic logic [N-1:0] rnd_word();
        logic [N-1:0] r;
        for (int i = 0; i < int'(N); i++) r[i] = 1'($urandom);
        return r;
    endfunction

    // Main stimulus.
    initial begin
        logic [N-1:0] m;
        int s;
        a = '0; b = '0; cin = 1'b0;
        void'($urandom(32'h5EED1234));
        apply('0, '0, 1'b0, "R1");
        apply('1, '0, 1'b1, "R6");
        apply(16'h5A3C, ~16'h5A3C, 1'b0, "R6");
        apply(16'h5A3C, ~16'h5A3C, 1'b1, "R6");
        apply(N'(1), '1, 1'b0, "R7");
        apply('1, '1, 1'b1, "R1");
        // Each segment all-propagating with a carry generated just below it.
        s = 0;
        for (int j = 0; j < int'(NSEG); j++) begin
            m = '0;
            for (int k = 0; k < int'(SEG_W[j]); k++) m[s+k] = 1'b1;
            apply(m, '0, 1'b1, "R9");
            if (s > 0) apply(m | N'(1 << (s-1)), N'(1 << (s-1)), 1'b0, "R9");
            else apply(m, '0, 1'b0, "R9");
            s += int'(SEG_W[j]);
        end
        if (N <= 8) begin
            for (int v = 0; v < (1 << (2*N+1)); v++)
                apply(N'(v), N'(v >> N), 1'((v >> (2*N)) & 1), "R1");
        end else begin
            for (int v = 0; v < 3000; v++)
                apply(rnd_word(), rnd_word(), 1'($urandom), "R1");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule